// File: doc/BRIEF.md
# USB Device Attach and Bus-Reset Sequencer

This block sits on the device side of a USB controller. It handles two jobs: attaching to the bus under software control, and reacting to a reset that the host drives on the bus. A software connect input sets the transceiver mode. When the input is low, the transceiver does not drive the lines. When it is high, the transceiver runs in normal mode and its D+ and D- drivers are enabled.

After attaching, the block passes no bus events to the rest of the controller. The one exception is a bus reset, which it recognises when the line stays in single-ended zero for a parameterised number of consecutive cycles. A detected reset starts a fixed sequence of one-cycle strobes:
- clear the device address;
- clear the endpoint index;
- flush every endpoint FIFO;
- wait until every FIFO has acknowledged the flush;
- clear the control and status registers;
- enable every endpoint interrupt;
- raise the reset interrupt.

After the sequence the block reports that it is ready for an address and lets bus events through. A later bus reset runs the sequence again. Dropping the connect input stops everything at once.

Top module: `usbd_attach_rst`

## Requirements
- R1: One clock edge after `sw_connect_i` is sampled low, `phy_normal_o` and `line_drv_en_o` are 0. One clock edge after it is sampled high, both are 1.
- R2: While attached but not yet ready, and during the cleanup sequence, `bus_evt_o` stays 0 whatever `bus_evt_i` does, and `addr_ready_o` is 0.
- R3: A single-ended-zero run of fewer than RST_CYCLES consecutive sampled cycles produces no strobe. A run of RST_CYCLES cycles raises `addr_clr_o` right after the clock edge that samples the RST_CYCLES-th consecutive single-ended-zero cycle.
- R4: The cleanup strobes start in this order on consecutive cycles: `addr_clr_o`, then `epidx_clr_o`, then `ep_flush_o` with all NUM_EP bits set.
- R5: `csr_clr_o` waits until every endpoint has returned a one-cycle pulse on its bit of `ep_flush_ack_i`, in any order and after any delay. It is then followed on consecutive cycles by `ep_ie_set_o` with all bits set and then `reset_irq_o`.
- R6: In the cycle after `reset_irq_o`, `addr_ready_o` is 1. While ready, `bus_evt_o` follows `bus_evt_i` in the same cycle.
- R7: A single-ended-zero run that lasts far beyond RST_CYCLES starts only one cleanup sequence. Detection rearms only after the line leaves single-ended zero.
- R8: A new bus reset in the ready state runs the full cleanup sequence again and ends ready again.
- R9: Dropping `sw_connect_i` at any point ends the sequence, and no further strobe follows. While disconnected, single-ended zero has no effect.
- R10: Each strobe lasts one cycle, and no two cleanup strobes are active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_connect_i | input | 1 | Software connect request |
| line_se0_i | input | 1 | Bus line currently in single-ended zero |
| bus_evt_i | input | 1 | Decoded bus signaling event from the receiver |
| ep_flush_ack_i | input | NUM_EP | One-cycle flush-complete pulse per endpoint FIFO |
| phy_normal_o | output | 1 | Transceiver in normal mode (0 = non-driving) |
| line_drv_en_o | output | 1 | D+/D- driver enable |
| bus_evt_o | output | 1 | Bus event passed on to the controller |
| addr_clr_o | output | 1 | Strobe: clear device address |
| epidx_clr_o | output | 1 | Strobe: clear endpoint index |
| ep_flush_o | output | NUM_EP | Strobe: flush each endpoint FIFO |
| csr_clr_o | output | 1 | Strobe: clear control/status registers |
| ep_ie_set_o | output | NUM_EP | Strobe: set each endpoint interrupt enable |
| reset_irq_o | output | 1 | Strobe: bus-reset interrupt |
| addr_ready_o | output | 1 | Default state reached, ready for an address |

## Verification
The hardest situation to reach is a disconnect while the sequence is stalled, waiting for flush acknowledgements. The bench slows its acknowledgement model so the block stays in that wait, drops the connect input there, and then lets the late acknowledgements arrive. It checks that no control/status clear or interrupt ever appears. It also holds single-ended zero for exactly one cycle less than the threshold and for exactly the threshold, to pin down the edge of detection. It then holds single-ended zero for three times the threshold to show that only one sequence starts.

// File: rtl/usbd_attach_pkg.sv
package usbd_attach_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_ATTACHED,
    ST_CLR_ADDR,
    ST_CLR_IDX,
    ST_FLUSH,
    ST_WAIT_FLUSH,
    ST_CLR_CSR,
    ST_IE_SET,
    ST_RST_IRQ,
    ST_DEFAULT
  } seq_state_e;

endpackage

// File: rtl/usbd_se0_timer.sv
module usbd_se0_timer #(
  parameter int RST_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic se0_i,
  output logic hit_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RST_CYCLES);
  localparam logic [CW-1:0] LAST  = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // saturating run-length counter; rearms only when the line leaves SE0 (R7)
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!enable_i || !se0_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != LIMIT) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit_o = enable_i && se0_i && (cnt_q == LAST);

endmodule

// File: rtl/usbd_flush_track.sv
module usbd_flush_track #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              abort_i,
  input  logic [NUM_EP-1:0] ack_i,
  output logic              all_done_o
);
  logic [NUM_EP-1:0] pend_q;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic pend_d, pend_en;
    always_comb begin
      pend_d  = pend_q[g];
      pend_en = 1'b0;
      if (abort_i) begin
        pend_d  = 1'b0;
        pend_en = 1'b1;
      end else if (arm_i) begin
        pend_d  = 1'b1;
        pend_en = 1'b1;
      end else if (ack_i[g]) begin
        pend_d  = 1'b0;
        pend_en = 1'b1;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q[g] <= 1'b0;
      else if (pend_en) pend_q[g] <= pend_d;
    end
  end

  assign all_done_o = (pend_q == '0);

endmodule

// File: rtl/usbd_reset_seq.sv
module usbd_reset_seq
  import usbd_attach_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       connect_i,
  input  logic       rst_hit_i,
  input  logic       flush_done_i,
  output seq_state_e state_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!connect_i) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:        st_d = ST_ATTACHED;
        ST_ATTACHED,
        ST_DEFAULT:    if (rst_hit_i) st_d = ST_CLR_ADDR;
        ST_CLR_ADDR:   st_d = ST_CLR_IDX;
        ST_CLR_IDX:    st_d = ST_FLUSH;
        ST_FLUSH:      st_d = ST_WAIT_FLUSH;
        ST_WAIT_FLUSH: begin
          if (rst_hit_i)         st_d = ST_CLR_ADDR;
          else if (flush_done_i) st_d = ST_CLR_CSR;
        end
        ST_CLR_CSR:    st_d = ST_IE_SET;
        ST_IE_SET:     st_d = ST_RST_IRQ;
        ST_RST_IRQ:    st_d = ST_DEFAULT;
        default:       st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/usbd_attach_rst.sv
module usbd_attach_rst
  import usbd_attach_pkg::*;
#(
  parameter int NUM_EP     = 4,
  parameter int RST_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_connect_i,
  input  logic              line_se0_i,
  input  logic              bus_evt_i,
  input  logic [NUM_EP-1:0] ep_flush_ack_i,
  output logic              phy_normal_o,
  output logic              line_drv_en_o,
  output logic              bus_evt_o,
  output logic              addr_clr_o,
  output logic              epidx_clr_o,
  output logic [NUM_EP-1:0] ep_flush_o,
  output logic              csr_clr_o,
  output logic [NUM_EP-1:0] ep_ie_set_o,
  output logic              reset_irq_o,
  output logic              addr_ready_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  seq_state_e state;
  logic       attached, rst_hit, flush_done;

  assign attached = (state != ST_OFF);

  usbd_se0_timer #(.RST_CYCLES(RST_CYCLES)) u_se0 (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .enable_i (attached),
    .se0_i    (line_se0_i),
    .hit_o    (rst_hit)
  );

  usbd_flush_track #(.NUM_EP(NUM_EP)) u_flush (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .arm_i      (state == ST_FLUSH),
    .abort_i    (state == ST_OFF),
    .ack_i      (ep_flush_ack_i),
    .all_done_o (flush_done)
  );

  usbd_reset_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .connect_i    (sw_connect_i),
    .rst_hit_i    (rst_hit),
    .flush_done_i (flush_done),
    .state_o      (state)
  );

  assign phy_normal_o  = attached;
  assign line_drv_en_o = attached;
  assign addr_ready_o  = (state == ST_DEFAULT);
  assign bus_evt_o     = bus_evt_i && addr_ready_o;
  assign addr_clr_o    = (state == ST_CLR_ADDR);
  assign epidx_clr_o   = (state == ST_CLR_IDX);
  assign ep_flush_o    = {NUM_EP{state == ST_FLUSH}};
  assign csr_clr_o     = (state == ST_CLR_CSR);
  assign ep_ie_set_o   = {NUM_EP{state == ST_IE_SET}};
  assign reset_irq_o   = (state == ST_RST_IRQ);

endmodule

// File: rtl/usbd_attach_rst_chk.sv
module usbd_attach_rst_chk #(
  parameter int NUM_EP = 4
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              sw_connect_i,
  input logic              bus_evt_o,
  input logic              phy_normal_o,
  input logic              addr_clr_o,
  input logic              epidx_clr_o,
  input logic [NUM_EP-1:0] ep_flush_o,
  input logic              csr_clr_o,
  input logic [NUM_EP-1:0] ep_ie_set_o,
  input logic              reset_irq_o,
  input logic              addr_ready_o
);
  logic [5:0] strobes;
  assign strobes = {addr_clr_o, epidx_clr_o, |ep_flush_o, csr_clr_o, |ep_ie_set_o, reset_irq_o};

  assert_connect_on_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    sw_connect_i |=> phy_normal_o);
  assert_connect_off_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !sw_connect_i |=> !phy_normal_o);
  assert_evt_gated_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !addr_ready_o |-> !bus_evt_o);
  assert_addr_then_idx_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (addr_clr_o && sw_connect_i) |=> epidx_clr_o);
  assert_idx_then_flush_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (epidx_clr_o && sw_connect_i) |=> (ep_flush_o == {NUM_EP{1'b1}}));
  assert_csr_then_ie_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (csr_clr_o && sw_connect_i) |=> (ep_ie_set_o == {NUM_EP{1'b1}}));
  assert_ie_then_irq_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (|ep_ie_set_o && sw_connect_i) |=> reset_irq_o);
  assert_irq_then_ready_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (reset_irq_o && sw_connect_i) |=> addr_ready_o);
  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !sw_connect_i |=> (strobes == 6'b0));
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(strobes));
  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    reset_irq_o |=> !reset_irq_o);

endmodule

bind usbd_attach_rst usbd_attach_rst_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk          (clk),
  .rst_ni       (rst_sync_n),
  .sw_connect_i (sw_connect_i),
  .bus_evt_o    (bus_evt_o),
  .phy_normal_o (phy_normal_o),
  .addr_clr_o   (addr_clr_o),
  .epidx_clr_o  (epidx_clr_o),
  .ep_flush_o   (ep_flush_o),
  .csr_clr_o    (csr_clr_o),
  .ep_ie_set_o  (ep_ie_set_o),
  .reset_irq_o  (reset_irq_o),
  .addr_ready_o (addr_ready_o)
);

// File: tb/usbd_attach_rst_tb_top.sv
module usbd_attach_rst_tb_top;
  localparam int NUM_EP     = 4;
  localparam int RST_CYCLES = 250;

  localparam logic [5:0] C_ADDR  = 6'b100000;
  localparam logic [5:0] C_IDX   = 6'b010000;
  localparam logic [5:0] C_FLUSH = 6'b001000;
  localparam logic [5:0] C_CSR   = 6'b000100;
  localparam logic [5:0] C_IE    = 6'b000010;
  localparam logic [5:0] C_IRQ   = 6'b000001;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, sw_connect, line_se0, bus_evt_in;
  logic [NUM_EP-1:0] ep_ack;
  logic              phy_normal, drv_en, bus_evt_out, addr_clr, epidx_clr;
  logic [NUM_EP-1:0] ep_flush, ep_ie_set;
  logic              csr_clr, reset_irq, addr_ready;

  usbd_attach_rst #(.NUM_EP(NUM_EP), .RST_CYCLES(RST_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_connect_i(sw_connect), .line_se0_i(line_se0),
    .bus_evt_i(bus_evt_in), .ep_flush_ack_i(ep_ack), .phy_normal_o(phy_normal),
    .line_drv_en_o(drv_en), .bus_evt_o(bus_evt_out), .addr_clr_o(addr_clr),
    .epidx_clr_o(epidx_clr), .ep_flush_o(ep_flush), .csr_clr_o(csr_clr),
    .ep_ie_set_o(ep_ie_set), .reset_irq_o(reset_irq), .addr_ready_o(addr_ready)
  );

  int         vec_cnt = 0;
  int         miss_cnt = 0;
  logic [5:0] exp_q[$];
  int         ack_gap = 2;
  bit         acks_done = 1'b0;
  bit         mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (!ok) begin
      miss_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_full();
    exp_q.push_back(C_ADDR); exp_q.push_back(C_IDX); exp_q.push_back(C_FLUSH);
    exp_q.push_back(C_CSR);  exp_q.push_back(C_IE);  exp_q.push_back(C_IRQ);
  endtask

  task automatic hold_se0(input int n);
    @(posedge clk); #1 line_se0 = 1'b1;
    repeat (n) @(posedge clk);
    #1 line_se0 = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!addr_ready && n < 2000) begin @(negedge clk); n++; end
    chk(addr_ready, req, addr_ready, 1);
  endtask

  // monitor: compares each observed strobe with the scoreboard queue
  always @(negedge clk) begin
    if (mon_on) begin
      logic [5:0] code, e;
      code = {addr_clr, epidx_clr, |ep_flush, csr_clr, |ep_ie_set, reset_irq};
      if (code != 6'b0) begin
        chk($countones(code) == 1, "R10 exclusive strobes", code, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected strobe", code, 0);
        end else begin
          e = exp_q.pop_front();
          chk(code == e, "R4/R5 strobe order", code, e);
        end
        if (code == C_FLUSH) chk(ep_flush == '1, "R4 flush all", ep_flush, {NUM_EP{1'b1}});
        if (code == C_IE)    chk(ep_ie_set == '1, "R5 ie all", ep_ie_set, {NUM_EP{1'b1}});
        if (code == C_CSR)   chk(acks_done, "R5 csr waits acks", acks_done, 1);
      end
    end
  end

  // flush acknowledgement model: endpoints answer in reverse order
  initial begin
    ep_ack = '0;
    forever begin
      @(negedge clk);
      if (|ep_flush) begin
        acks_done = 1'b0;
        for (int i = NUM_EP - 1; i >= 0; i--) begin
          repeat (ack_gap) @(posedge clk);
          #1 ep_ack[i] = 1'b1;
          @(posedge clk);
          #1 ep_ack[i] = 1'b0;
        end
        acks_done = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss_cnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sw_connect = 1'b0; line_se0 = 1'b0; bus_evt_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    mon_on = 1'b1;
    @(negedge clk);
    chk(!phy_normal && !drv_en, "R1 reset non-driving", {phy_normal, drv_en}, 0);
    chk(!addr_ready, "R2 reset not ready", addr_ready, 0);

    // connect
    @(posedge clk); #1 sw_connect = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(phy_normal && drv_en, "R1 connect normal", {phy_normal, drv_en}, 3);
    bus_evt_in = 1'b1; @(negedge clk);
    chk(!bus_evt_out, "R2 attached gates events", bus_evt_out, 0);
    bus_evt_in = 1'b0;

    // short SE0: one below threshold
    hold_se0(RST_CYCLES - 1);
    repeat (10) @(negedge clk);
    chk(!addr_ready && !addr_clr, "R3 short SE0 ignored", addr_ready, 0);

    // exact threshold
    push_full();
    hold_se0(RST_CYCLES);
    @(negedge clk);
    chk(addr_clr, "R3 detect at threshold", addr_clr, 1);
    bus_evt_in = 1'b1; @(negedge clk);
    chk(!bus_evt_out, "R2 cleanup gates events", bus_evt_out, 0);
    bus_evt_in = 1'b0;
    wait_ready("R6 ready after cleanup");
    bus_evt_in = 1'b1; #1;
    chk(bus_evt_out, "R6 events pass", bus_evt_out, 1);
    bus_evt_in = 1'b0; #1;
    chk(!bus_evt_out, "R6 events follow", bus_evt_out, 0);

    // long SE0 from ready: one sequence only (R7, R8)
    push_full();
    hold_se0(3 * RST_CYCLES);
    wait_ready("R8 ready after second reset");
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7 single sequence", exp_q.size(), 0);

    // abort during flush wait
    ack_gap = 20;
    exp_q.push_back(C_ADDR); exp_q.push_back(C_IDX); exp_q.push_back(C_FLUSH);
    hold_se0(RST_CYCLES);
    repeat (8) @(posedge clk);
    #1 sw_connect = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!phy_normal, "R9 abort non-driving", phy_normal, 0);
    repeat (120) @(negedge clk);
    chk(exp_q.size() == 0 && !addr_ready, "R9 no strobes after abort", exp_q.size(), 0);

    // SE0 while disconnected
    hold_se0(RST_CYCLES + 10);
    repeat (10) @(negedge clk);
    chk(!addr_ready && !phy_normal, "R9 SE0 ignored disconnected", addr_ready, 0);

    // reconnect, then two resets back to back
    ack_gap = 1;
    @(posedge clk); #1 sw_connect = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(phy_normal && !addr_ready, "R2 reattached not ready", {phy_normal, addr_ready}, 2);
    push_full();
    hold_se0(RST_CYCLES);
    wait_ready("R6 ready again");
    push_full();
    hold_se0(RST_CYCLES + 3);
    wait_ready("R8 repeated reset");
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

endmodule